// File: doc/BRIEF.md
# Thread-to-Core-Type Assignment Arbiter

This block sits between the per-thread core-type selectors of a shared processor and the migration machinery. The processor has as many core types as it runs threads. Each thread reports the core type it would like to run on. The block turns these requests into a one-to-one mapping of threads onto core types.

Where several threads ask for the same type, a pseudo-random draw decides which of them keeps it. The remaining threads are then placed on the core types that nobody received. Threads that software has pinned keep their present core. That core is withheld from everyone else.

The block holds the current mapping as a status value, so that system software can tell which cores host a thread that is about to move. It also raises a one-cycle migrate strobe for each thread whose core type changed in an arbitration.

Top module: `core_arb`

## Requirements
- R1: After reset the mapping is the identity: thread t is on core type t (each entry is a CW-bit field at bits [CW*t +: CW] of `core_map`). `migrate` and `done` are both low.
- R2: An arbitration samples `pref_core` and `pin_mask` on the first clock edge at which the block is idle and every bit of `pref_valid` is 1. The new mapping, `migrate` and a one-cycle `done` appear after the next clock edge. While any `pref_valid` bit is 0 in the idle state, nothing changes.
- R3: When no thread is pinned and the preferences are all distinct, every thread receives exactly its preferred core type.
- R4: For each core type c in ascending order that is still free, the unpinned threads preferring c are examined in the order o, o+1, ... modulo N. The offset o is the CW-bit value whose bit b is LFSR bit (CW*c+b) mod LFSR_W. The first thread found receives c.
- R5: Threads that did not receive a type in R4 are handled in ascending thread index. Each takes the lowest-numbered core type not yet assigned.
- R6: A thread whose `pin_mask` bit was 1 when sampled keeps its current core type and raises no migrate strobe. No other thread receives that core type in the same arbitration.
- R7: `migrate[t]` is 1 only in the `done` cycle, and only if thread t's core type differs from the one it held before that arbitration.
- R8: `core_map` is always a permutation of the core types and changes only in a `done` cycle.
- R9: The pseudo-random source is a 16-bit right-shifting Galois LFSR, seed 0xACE1. When the shifted-out bit is 1, the shifted value is XORed with 0xB400. Each arbitration uses the current value and then advances the LFSR exactly once.
- R10: After an arbitration, no new one starts until at least one `pref_valid` bit has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pref_valid | input | N | Per-thread preference valid |
| pref_core | input | N*CW | Per-thread preferred core type, CW bits per thread |
| pin_mask | input | N | Per-thread software pin: thread keeps its current core |
| core_map | output | N*CW | Status: current core type of each thread |
| migrate | output | N | One-cycle strobe per thread whose core type changed |
| done | output | 1 | One-cycle pulse when a new mapping is committed |

## Verification
The bench builds the block with its default parameters: CW = 2, so four threads and four core types, and the 16-bit LFSR. It applies every one of the 256 preference patterns under each of the 16 pin masks. Arbitrations run back to back, so the LFSR walks through 4096 successive states. Together these cover uncontested permutations, all-same requests, every pinned subset, and contention offsets at all rotation positions. A stretch with a partial valid vector and held-high valids around each commit covers the start and re-arm conditions.

// File: rtl/core_arb_pkg.sv
// Package: shared types for the core-type assignment arbiter.
package core_arb_pkg;

    // Sequencing states of one arbitration interval.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // waiting for all preferences
        ARB_CALC = 2'd1,   // resolving and committing
        ARB_HOLD = 2'd2    // waiting for the valid vector to drop
    } arb_state_e;

endpackage

// File: rtl/core_arb_lfsr.sv
// Module: core_arb_lfsr
// Right-shifting Galois LFSR used as the contention draw.
// Assumes: SEED is nonzero; step pulses at most once per arbitration.
module core_arb_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    TAPS = 16'hB400,
    parameter logic [W-1:0]    SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_nxt;

    // Next state: shift right, fold taps in when a one falls out.
    always_comb begin
        state_nxt = state_q >> 1;
        if (state_q[0]) begin
            state_nxt = state_nxt ^ TAPS;
        end
    end

    // State register, advanced only on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    assign value = state_q;

endmodule

// File: rtl/core_arb_ctrl.sv
// Module: core_arb_ctrl
// Sequences one arbitration per interval. Sampling happens once every
// preference is valid. The commit follows one cycle later. A further start
// waits until the valid vector has dropped.
// Assumes: all_valid is a registered or stable input level.
module core_arb_ctrl
    import core_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic all_valid,
    output logic capture,
    output logic commit
);

    arb_state_e state_q;
    arb_state_e state_nxt;

    // Transition and strobe decode.
    always_comb begin
        state_nxt = state_q;
        capture   = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (all_valid) begin
                    capture   = 1'b1;
                    state_nxt = ARB_CALC;
                end
            end
            ARB_CALC: begin
                commit    = 1'b1;
                state_nxt = ARB_HOLD;
            end
            ARB_HOLD: begin
                if (!all_valid) begin
                    state_nxt = ARB_IDLE;
                end
            end
            default: state_nxt = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

endmodule

// File: rtl/core_arb_resolve.sv
// Module: core_arb_resolve
// Combinational mapping from preferences to a permutation.
// Pinned threads keep their cores. Each free core type goes to a
// claimant picked by a rotating offset taken from the random word.
// Threads left over fill the free types in ascending order.
// Assumes: cur is a permutation, so pinned cores are distinct.
module core_arb_resolve #(
    parameter int CW = 2,
    parameter int RW = 16,
    localparam int N = 1 << CW
) (
    input  logic [N-1:0][CW-1:0] pref,
    input  logic [N-1:0]         pin,
    input  logic [N-1:0][CW-1:0] cur,
    input  logic [RW-1:0]        rnd,
    output logic [N-1:0][CW-1:0] nxt
);

    logic [N-1:0]  taken;
    logic [N-1:0]  placed;
    logic          won;
    logic          got;
    logic [CW-1:0] off;
    logic [CW-1:0] idx;

    // Three passes: pinned, contended winners, leftover fill.
    always_comb begin
        taken  = '0;
        placed = '0;
        nxt    = cur;
        won    = 1'b0;
        got    = 1'b0;
        off    = '0;
        idx    = '0;

        for (int t = 0; t < N; t++) begin
            if (pin[t]) begin
                taken[cur[t]] = 1'b1;
                placed[t]     = 1'b1;
            end
        end

        for (int c = 0; c < N; c++) begin
            for (int b = 0; b < CW; b++) begin
                off[b] = rnd[(c * CW + b) % RW];
            end
            won = 1'b0;
            for (int k = 0; k < N; k++) begin
                idx = off + CW'(k);
                if (!taken[c] && !won && !pin[idx] && (pref[idx] == CW'(c))) begin
                    nxt[idx]    = CW'(c);
                    placed[idx] = 1'b1;
                    won         = 1'b1;
                end
            end
            if (won) begin
                taken[c] = 1'b1;
            end
        end

        for (int t = 0; t < N; t++) begin
            if (!placed[t]) begin
                got = 1'b0;
                for (int c = 0; c < N; c++) begin
                    if (!got && !taken[c]) begin
                        nxt[t]   = CW'(c);
                        taken[c] = 1'b1;
                        got      = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/core_arb.sv
// Module: core_arb (top)
// Assigns each of N threads to a distinct one of N core types once per
// interval. Holds the mapping as status and strobes moved threads.
// Assumes: N = 2**CW; LFSR_W >= 2; LFSR_SEED nonzero.
module core_arb #(
    parameter int                 CW        = 2,
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1,
    localparam int                N         = 1 << CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pref_valid,
    input  logic [N*CW-1:0] pref_core,
    input  logic [N-1:0]    pin_mask,
    output logic [N*CW-1:0] core_map,
    output logic [N-1:0]    migrate,
    output logic            done
);

    logic                  capture;
    logic                  commit;
    logic [LFSR_W-1:0]     rnd;
    logic [N-1:0][CW-1:0]  pref_q;
    logic [N-1:0]          pin_q;
    logic [N-1:0][CW-1:0]  map_q;
    logic [N-1:0][CW-1:0]  map_nxt;
    logic [N-1:0]          moved;
    logic [N-1:0]          mig_q;
    logic                  done_q;

    core_arb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_valid (&pref_valid),
        .capture   (capture),
        .commit    (commit)
    );

    core_arb_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (commit),
        .value (rnd)
    );

    core_arb_resolve #(
        .CW (CW),
        .RW (LFSR_W)
    ) u_resolve (
        .pref (pref_q),
        .pin  (pin_q),
        .cur  (map_q),
        .rnd  (rnd),
        .nxt  (map_nxt)
    );

    // Sample preferences and pins at the start of an arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pref_q <= '0;
            pin_q  <= '0;
        end else if (capture) begin
            pref_q <= pref_core;
            pin_q  <= pin_mask;
        end
    end

    // Flag threads whose core type differs in the resolved mapping.
    always_comb begin
        for (int t = 0; t < N; t++) begin
            moved[t] = (map_nxt[t] != map_q[t]);
        end
    end

    // Commit the mapping and raise one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N; t++) begin
                map_q[t] <= CW'(t);
            end
            mig_q  <= '0;
            done_q <= 1'b0;
        end else if (commit) begin
            map_q  <= map_nxt;
            mig_q  <= moved;
            done_q <= 1'b1;
        end else begin
            mig_q  <= '0;
            done_q <= 1'b0;
        end
    end

    assign core_map = map_q;
    assign migrate  = mig_q;
    assign done     = done_q;

endmodule

// File: rtl/core_arb_chk.sv
// Module: core_arb_chk
// Temporal checks on the arbiter outputs, attached with bind below.
// Assumes: pin_q is the pin mask captured for the latest arbitration.
module core_arb_chk #(
    parameter int CW = 2,
    localparam int N = 1 << CW
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N*CW-1:0] core_map,
    input logic [N-1:0]    migrate,
    input logic            done,
    input logic [N-1:0]    pin_q
);

    logic [N-1:0] hit;

    // Mark every core type that some thread occupies.
    always_comb begin
        hit = '0;
        for (int t = 0; t < N; t++) begin
            hit[core_map[CW*t +: CW]] = 1'b1;
        end
    end

    // R8: every core type is occupied, so the mapping is a permutation.
    a_r8_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        &hit);

    // R8: the mapping moves only in a done cycle.
    a_r8_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(core_map));

    // R7: strobes appear only alongside done.
    a_r7_strobe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|migrate) |-> done);

    // R6: a pinned thread is never strobed.
    a_r6_pinned_stays: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((migrate & pin_q) == '0));

    // R10: done is a single-cycle pulse.
    a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a strobed thread really changed core type.
    for (genvar t = 0; t < N; t++) begin : g_mig
        a_r7_strobe_means_move: assert property (@(posedge clk) disable iff (!rst_n)
            migrate[t] |-> (core_map[CW*t +: CW] != $past(core_map[CW*t +: CW])));
    end

endmodule

bind core_arb core_arb_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_map (core_map),
    .migrate  (migrate),
    .done     (done),
    .pin_q    (pin_q)
);

// File: tb/sim_core_arb.sv
// Bench: sweeps every preference pattern under every pin mask.
// Expected mappings come from an arithmetic model of the rules.
module sim_core_arb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 2;
    localparam int N  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    pref_valid = '0;
    logic [N*CW-1:0] pref_core = '0;
    logic [N-1:0]    pin_mask = '0;
    logic [N*CW-1:0] core_map;
    logic [N-1:0]    migrate;
    logic            done;

    int   n_vec  = 0;
    int   n_fail = 0;
    bit   summary_done = 1'b0;

    int   m_pref [N];
    int   m_cur  [N];
    int   m_new  [N];
    bit   m_pin  [N];
    logic [15:0] m_lfsr = 16'hACE1;

    core_arb u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pref_valid (pref_valid),
        .pref_core  (pref_core),
        .pin_mask   (pin_mask),
        .core_map   (core_map),
        .migrate    (migrate),
        .done       (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // R9: model of the draw sequence.
    function automatic logic [15:0] lfsr_adv(input logic [15:0] s);
        logic [15:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ 16'hB400;
        return r;
    endfunction

    // Model of R4/R5/R6 for the current m_* state.
    task automatic model_resolve();
        bit used [N];
        bit fixed [N];
        for (int t = 0; t < N; t++) begin
            m_new[t] = m_cur[t];
            used[t]  = 1'b0;
            fixed[t] = 1'b0;
        end
        for (int t = 0; t < N; t++) begin
            if (m_pin[t]) begin
                used[m_cur[t]] = 1'b1;
                fixed[t] = 1'b1;
            end
        end
        for (int c = 0; c < N; c++) begin
            int start;
            start = (int'(m_lfsr) >> (2 * c)) & 3;
            for (int k = 0; k < N; k++) begin
                int th;
                th = (start + k) % N;
                if (!used[c] && !m_pin[th] && m_pref[th] == c) begin
                    m_new[th] = c;
                    used[c]   = 1'b1;
                    fixed[th] = 1'b1;
                end
            end
        end
        for (int t = 0; t < N; t++) begin
            if (!fixed[t]) begin
                int f;
                f = -1;
                for (int c = 0; c < N; c++) begin
                    if (f < 0 && !used[c]) f = c;
                end
                m_new[t] = f;
                used[f]  = 1'b1;
            end
        end
    endtask

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pack_map();
        int v;
        v = 0;
        for (int t = 0; t < N; t++) v = v | (m_cur[t] << (2 * t));
        return v;
    endfunction

    // One full arbitration with valids held one extra cycle.
    task automatic arbitrate(input int pins, input int prefs);
        int exp_map;
        int exp_mig;
        @(negedge clk);
        pref_valid = '1;
        pref_core  = prefs[N*CW-1:0];
        pin_mask   = pins[N-1:0];
        for (int t = 0; t < N; t++) begin
            m_pref[t] = (prefs >> (2 * t)) & 3;
            m_pin[t]  = pins[t];
        end
        model_resolve();
        exp_map = 0;
        exp_mig = 0;
        for (int t = 0; t < N; t++) begin
            exp_map = exp_map | (m_new[t] << (2 * t));
            if (m_new[t] != m_cur[t]) exp_mig = exp_mig | (1 << t);
        end
        @(negedge clk);
        check("R2 latency", done == 1'b0, int'(done), 0);
        @(negedge clk);
        check("R2 done", done == 1'b1, int'(done), 1);
        check("R3 R4 R5 R6 R9 map", core_map == exp_map[N*CW-1:0], int'(core_map), exp_map);
        check("R7 migrate", migrate == exp_mig[N-1:0], int'(migrate), exp_mig);
        for (int t = 0; t < N; t++) m_cur[t] = m_new[t];
        m_lfsr = lfsr_adv(m_lfsr);
        @(negedge clk);
        check("R10 no restart", done == 1'b0, int'(done), 0);
        check("R8 map hold", core_map == exp_map[N*CW-1:0], int'(core_map), exp_map);
        pref_valid = '0;
        @(negedge clk);
    endtask

    initial begin
        for (int t = 0; t < N; t++) m_cur[t] = t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 map", core_map == 8'hE4, int'(core_map), 8'hE4);
        check("R1 migrate", migrate == '0, int'(migrate), 0);
        check("R1 done", done == 1'b0, int'(done), 0);

        // R2: a partial valid vector starts nothing.
        pref_valid = 4'b0111;
        pref_core  = 8'h00;
        repeat (4) begin
            @(negedge clk);
            check("R2 partial valid", done == 1'b0 && core_map == 8'hE4, int'(core_map), 8'hE4);
        end
        pref_valid = '0;
        @(negedge clk);

        // Exhaustive sweep: every pin mask, every preference pattern.
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 256; q++) begin
                arbitrate(p, q);
            end
        end

        summary_done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!summary_done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule